// File: doc/BRIEF.md
# Decimal Accumulator Processor Core

This block is a small multi-cycle accumulator machine. Every value it handles is a decimal number stored as binary-coded decimal, one 4-bit nibble per digit. A data word has four digits. An address has three digits, so the internal memory holds 1000 words. The program counter, instruction register, accumulator, memory address register and memory buffer register each load at most once per clock. The control unit moves values between them in a fixed sequence of single-cycle micro-steps.

An instruction word has two parts. Its most significant digit is the opcode and its three low digits are an operand address. The core always runs the same loop: fetch, execute, then a check for a pending interrupt. When an interrupt is taken, the core saves the program counter in a shadow register, jumps to a start address set by a parameter, and ignores further requests until a return instruction restores the saved address.

A testbench or loader fills the memory through a preload write port. It normally does this while reset is held. Debug outputs show the architectural registers at all times.

Top module: `dec_acc_core`

## Requirements
- R1: While reset is asserted, and after it is released, the PC, IR, AC, MAR and MBR outputs read zero and `halted` is low. The reset release passes through a two-stage synchronizer, so the first micro-step happens on the third rising clock edge after `rst_n` goes high. Execution starts at address 000.
- R2: A fetch takes four single-cycle steps, in this order: MAR is loaded from PC; MBR is loaded from the memory word addressed by MAR; IR is loaded from MBR; PC is advanced by one.
- R3: Every digit is a BCD nibble. In an instruction, bits 15:12 hold the opcode and bits 11:0 hold a three-digit operand address. Opcode 1 (load) runs in three steps: MAR is loaded from IR bits 11:0, MBR is loaded from memory, and AC is loaded from MBR. AC changes only in the final step of an execute.
- R4: Opcode 2 (store) runs in three steps: MAR is loaded from the operand field, MBR is loaded from AC, and the memory word at MAR is loaded from MBR.
- R5: Opcode 3 (add) reads memory the same way a load does. It then loads AC with the decimal sum of AC and MBR. The sum carries from digit to digit and wraps modulo 10000. For example, 0999+0001=1000 and 9999+0002=0001.
- R6: Opcode 0 halts the core. `halted` goes high and stays high, and PC, AC and IR stay frozen until reset. A load, store or add instruction takes 8 cycles. A halt is recognised in the 5th cycle of its own instruction.
- R7: PC advances in decimal, one digit at a time, and wraps from 999 to 000.
- R8: After every execute phase there is one interrupt-check cycle. If `irq` is high and interrupts are not masked, the PC is copied into the shadow register, PC is loaded with `ISR_ADDR`, and interrupts become masked.
- R9: While interrupts are masked, `irq` has no effect. Opcode 9 (return) copies the shadow register back into PC and removes the mask.
- R10: Opcodes 4 to 8 leave AC and memory unchanged, and execution continues with the next instruction. Such an instruction takes 6 cycles.
- R11: On a rising clock edge with `pl_we` high, the word `pl_data` is written at address `pl_addr`. This works while reset is held, and a preload write takes priority over a store from the core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 12 | Preload address, three BCD digits |
| pl_data | input | 16 | Preload data, four BCD digits |
| irq | input | 1 | Level-sensitive interrupt request |
| halted | output | 1 | High once a halt opcode has executed |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_ac | output | 16 | Accumulator |
| dbg_mar | output | 12 | Memory address register |
| dbg_mbr | output | 16 | Memory buffer register |

## Verification
The debug taps expose every architectural register after each micro-step. Because of this, a wrong step order or a wrong register source shows up on the outputs within one cycle of the faulty step. A carry error in a digit, a wrong return address or a lost store does not show up straight away. It appears in the AC value, or the PC value, that remains when the program halts, a few instructions later. A fault in sequencing or masking, such as a missed or repeated interrupt or a missed halt, shows up either as a wrong halt cycle count or as a handler that runs more than once and changes the final AC.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  // Micro-step states of the control unit.
  typedef enum logic [3:0] {
    ST_F_MAR   = 4'd0,
    ST_F_MBR   = 4'd1,
    ST_F_IR    = 4'd2,
    ST_F_PC    = 4'd3,
    ST_E_MAR   = 4'd4,
    ST_E_MBR   = 4'd5,
    ST_E_FIN   = 4'd6,
    ST_INT_CHK = 4'd7,
    ST_HALT    = 4'd8
  } dacc_state_e;

  // Opcode values, taken from the top digit of the instruction word.
  localparam logic [3:0] OP_HALT  = 4'd0;
  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_STORE = 4'd2;
  localparam logic [3:0] OP_ADD   = 4'd3;
  localparam logic [3:0] OP_RET   = 4'd9;

  // Register-transfer enables issued by the sequencer in each cycle.
  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mbr_from_mem;
    logic mbr_from_ac;
    logic ir_from_mbr;
    logic pc_step;
    logic ac_from_mbr;
    logic ac_from_sum;
    logic mem_wr;
    logic irq_take;
    logic irq_ret;
  } dacc_ctl_t;

  // Converts up to 8 BCD digits into a binary index.
  function automatic int unsigned bcd_to_index(input logic [31:0] bcd,
                                               input int unsigned ndig);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < 8; k++) begin
      if ((7 - k) < ndig) begin
        acc = acc * 10 + 32'(bcd[4*(7-k) +: 4]);
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/dacc_bcd_add.sv
module dacc_bcd_add #(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = 4 * DIGITS
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);

  logic [DIGITS-1:0] carry;

  assign carry[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    logic       ovf;
    logic [4:0] adj;

    assign raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0000, carry[g]};
    assign ovf = (raw > 5'd9);
    assign adj = raw + 5'd6;
    assign sum[4*g +: 4] = ovf ? adj[3:0] : raw[3:0];

    if (g < DIGITS - 1) begin : g_chain
      assign carry[g+1] = ovf;
    end
  end

endmodule

// File: rtl/dacc_mem.sv
module dacc_mem
  import dacc_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned ADDR_DIGITS = 3,
  localparam int unsigned ADDR_W     = 4 * ADDR_DIGITS
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned DEPTH = 10 ** ADDR_DIGITS;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [WORD_W-1:0] words_q [DEPTH];
  logic [IDX_W-1:0]  widx;
  logic [IDX_W-1:0]  ridx;

  assign widx = IDX_W'(bcd_to_index(32'(waddr), ADDR_DIGITS));
  assign ridx = IDX_W'(bcd_to_index(32'(raddr), ADDR_DIGITS));

  always_ff @(posedge clk) begin
    if (we) begin
      words_q[widx] <= wdata;
    end
  end

  assign rdata = words_q[ridx];

endmodule

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  opcode,
  input  logic        irq,
  input  logic        masked,
  output dacc_state_e state,
  output dacc_ctl_t   ctl,
  output logic        halted
);

  dacc_state_e state_q;
  dacc_state_e state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    unique case (state_q)
      ST_F_MAR: begin
        ctl.mar_from_pc = 1'b1;
        state_d = ST_F_MBR;
      end
      ST_F_MBR: begin
        ctl.mbr_from_mem = 1'b1;
        state_d = ST_F_IR;
      end
      ST_F_IR: begin
        ctl.ir_from_mbr = 1'b1;
        state_d = ST_F_PC;
      end
      ST_F_PC: begin
        ctl.pc_step = 1'b1;
        state_d = ST_E_MAR;
      end
      ST_E_MAR: begin
        if (opcode == OP_HALT) begin
          state_d = ST_HALT;
        end else if (opcode == OP_LOAD || opcode == OP_STORE || opcode == OP_ADD) begin
          ctl.mar_from_ir = 1'b1;
          state_d = ST_E_MBR;
        end else if (opcode == OP_RET) begin
          ctl.irq_ret = 1'b1;
          state_d = ST_INT_CHK;
        end else begin
          state_d = ST_INT_CHK;
        end
      end
      ST_E_MBR: begin
        if (opcode == OP_STORE) begin
          ctl.mbr_from_ac = 1'b1;
        end else begin
          ctl.mbr_from_mem = 1'b1;
        end
        state_d = ST_E_FIN;
      end
      ST_E_FIN: begin
        if (opcode == OP_LOAD) begin
          ctl.ac_from_mbr = 1'b1;
        end else if (opcode == OP_ADD) begin
          ctl.ac_from_sum = 1'b1;
        end else begin
          ctl.mem_wr = 1'b1;
        end
        state_d = ST_INT_CHK;
      end
      ST_INT_CHK: begin
        ctl.irq_take = irq & ~masked;
        state_d = ST_F_MAR;
      end
      ST_HALT: begin
        state_d = ST_HALT;
      end
      default: begin
        state_d = ST_HALT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_F_MAR;
    end else begin
      state_q <= state_d;
    end
  end

  assign state  = state_q;
  assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/dec_acc_core.sv
module dec_acc_core
  import dacc_pkg::*;
#(
  parameter int unsigned DIGITS      = 4,
  parameter int unsigned ADDR_DIGITS = 3,
  localparam int unsigned WORD_W     = 4 * DIGITS,
  localparam int unsigned ADDR_W     = 4 * ADDR_DIGITS,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 12'h900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [WORD_W-1:0] pl_data,
  input  logic              irq,
  output logic              halted,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [WORD_W-1:0] dbg_ir,
  output logic [WORD_W-1:0] dbg_ac,
  output logic [ADDR_W-1:0] dbg_mar,
  output logic [WORD_W-1:0] dbg_mbr
);

  // Reset synchronizer: the reset asserts asynchronously and releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // Architectural registers.
  logic [ADDR_W-1:0] pc_q,  pc_d;
  logic [WORD_W-1:0] ir_q,  ir_d;
  logic [WORD_W-1:0] ac_q,  ac_d;
  logic [ADDR_W-1:0] mar_q, mar_d;
  logic [WORD_W-1:0] mbr_q, mbr_d;
  logic [ADDR_W-1:0] shadow_q, shadow_d;
  logic              mask_q, mask_d;

  dacc_state_e       state;
  dacc_ctl_t         ctl;
  logic [3:0]        opcode;
  logic [ADDR_W-1:0] pc_inc;
  logic [WORD_W-1:0] ac_sum;
  logic [WORD_W-1:0] mem_rdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata;

  assign opcode = ir_q[WORD_W-1 -: 4];

  dacc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .opcode (opcode),
    .irq    (irq),
    .masked (mask_q),
    .state  (state),
    .ctl    (ctl),
    .halted (halted)
  );

  dacc_bcd_add #(.DIGITS(ADDR_DIGITS)) u_pc_inc (
    .a   (pc_q),
    .b   ('0),
    .cin (1'b1),
    .sum (pc_inc)
  );

  dacc_bcd_add #(.DIGITS(DIGITS)) u_ac_add (
    .a   (ac_q),
    .b   (mbr_q),
    .cin (1'b0),
    .sum (ac_sum)
  );

  // A preload write wins over a store issued by the core.
  assign mem_we    = pl_we | ctl.mem_wr;
  assign mem_waddr = pl_we ? pl_addr : mar_q;
  assign mem_wdata = pl_we ? pl_data : mbr_q;

  dacc_mem #(.WORD_W(WORD_W), .ADDR_DIGITS(ADDR_DIGITS)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar_q),
    .rdata (mem_rdata)
  );

  // Next-state logic for the register file.
  always_comb begin
    pc_d     = pc_q;
    ir_d     = ir_q;
    ac_d     = ac_q;
    mar_d    = mar_q;
    mbr_d    = mbr_q;
    shadow_d = shadow_q;
    mask_d   = mask_q;

    if (ctl.mar_from_pc)  mar_d = pc_q;
    if (ctl.mar_from_ir)  mar_d = ir_q[ADDR_W-1:0];
    if (ctl.mbr_from_mem) mbr_d = mem_rdata;
    if (ctl.mbr_from_ac)  mbr_d = ac_q;
    if (ctl.ir_from_mbr)  ir_d  = mbr_q;
    if (ctl.pc_step)      pc_d  = pc_inc;
    if (ctl.ac_from_mbr)  ac_d  = mbr_q;
    if (ctl.ac_from_sum)  ac_d  = ac_sum;
    if (ctl.irq_take) begin
      shadow_d = pc_q;
      pc_d     = ISR_ADDR;
      mask_d   = 1'b1;
    end
    if (ctl.irq_ret) begin
      pc_d   = shadow_q;
      mask_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      ac_q     <= '0;
      mar_q    <= '0;
      mbr_q    <= '0;
      shadow_q <= '0;
      mask_q   <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      ir_q     <= ir_d;
      ac_q     <= ac_d;
      mar_q    <= mar_d;
      mbr_q    <= mbr_d;
      shadow_q <= shadow_d;
      mask_q   <= mask_d;
    end
  end

  assign dbg_pc  = pc_q;
  assign dbg_ir  = ir_q;
  assign dbg_ac  = ac_q;
  assign dbg_mar = mar_q;
  assign dbg_mbr = mbr_q;

endmodule

// File: rtl/dacc_checker.sv
module dacc_checker
  import dacc_pkg::*;
#(
  parameter int unsigned DIGITS      = 4,
  parameter int unsigned ADDR_DIGITS = 3,
  localparam int unsigned WORD_W     = 4 * DIGITS,
  localparam int unsigned ADDR_W     = 4 * ADDR_DIGITS
) (
  input logic              clk,
  input logic              rst_n,
  input dacc_state_e       state,
  input logic              halted,
  input logic              mask,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] ir,
  input logic [WORD_W-1:0] ac,
  input logic [ADDR_W-1:0] mar,
  input logic [ADDR_W-1:0] isr_addr
);

  for (genvar g = 0; g < ADDR_DIGITS; g++) begin : g_pc_dig
    assert_pc_digit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pc[4*g +: 4] <= 4'd9);
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_ac_dig
    assert_ac_digit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ac[4*g +: 4] <= 4'd9);
  end

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc) && $stable(ac) && $stable(ir)));

  assert_ac_final_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ac) |-> ($past(state) == ST_E_FIN));

  assert_mar_operand_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_E_MBR) |-> (mar == ir[ADDR_W-1:0]));

  assert_irq_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask) |-> (pc == isr_addr));

  assert_unmask_on_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mask) |-> ($past(ir[WORD_W-1 -: 4]) == OP_RET));

endmodule

bind dec_acc_core dacc_checker #(
  .DIGITS      (DIGITS),
  .ADDR_DIGITS (ADDR_DIGITS)
) u_dacc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .state    (state),
  .halted   (halted),
  .mask     (mask_q),
  .pc       (pc_q),
  .ir       (ir_q),
  .ac       (ac_q),
  .mar      (mar_q),
  .isr_addr (ISR_ADDR)
);

// File: tb/test_dec_acc_core.sv
module test_dec_acc_core;

  logic        clk;
  logic        rst_n;
  logic        pl_we;
  logic [11:0] pl_addr;
  logic [15:0] pl_data;
  logic        irq;
  logic        halted;
  logic [11:0] dbg_pc;
  logic [15:0] dbg_ir;
  logic [15:0] dbg_ac;
  logic [11:0] dbg_mar;
  logic [15:0] dbg_mbr;

  int n_run;
  int n_fail;
  int cyc;

  dec_acc_core #(.ISR_ADDR(12'h998)) i_dec_acc_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .pl_we   (pl_we),
    .pl_addr (pl_addr),
    .pl_data (pl_data),
    .irq     (irq),
    .halted  (halted),
    .dbg_pc  (dbg_pc),
    .dbg_ir  (dbg_ir),
    .dbg_ac  (dbg_ac),
    .dbg_mar (dbg_mar),
    .dbg_mbr (dbg_mbr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got %0d cycles expected fewer than 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    irq   = 1'b0;
    pl_we = 1'b0;
    step();
    step();
  endtask

  task automatic preload(input logic [11:0] a, input logic [15:0] d);
    pl_addr = a;
    pl_data = d;
    pl_we   = 1'b1;
    step();
    pl_we   = 1'b0;
  endtask

  // Two edges for the reset synchronizer; the next step is micro-step 1.
  task automatic release_reset();
    rst_n = 1'b1;
    step();
    step();
  endtask

  task automatic run_to_halt(output int steps);
    steps = 0;
    while (!halted && steps < 1000) begin
      step();
      steps++;
    end
    chk("R6", "halt reached", {31'd0, halted}, 32'd1);
  endtask

  task automatic t_reset();
    int s;
    hold_reset();
    preload(12'h000, 16'h0000);
    chk("R1", "pc in reset", 32'(dbg_pc), 32'h000);
    chk("R1", "ac in reset", 32'(dbg_ac), 32'h0000);
    chk("R1", "ir in reset", 32'(dbg_ir), 32'h0000);
    chk("R1", "halted in reset", {31'd0, halted}, 32'd0);
    release_reset();
    chk("R1", "mar after sync", 32'(dbg_mar), 32'h000);
    chk("R1", "mbr after sync", 32'(dbg_mbr), 32'h0000);
    run_to_halt(s);
  endtask

  task automatic t_micro();
    int s;
    hold_reset();
    preload(12'h000, 16'h1450);
    preload(12'h001, 16'h0000);
    preload(12'h450, 16'h0733);
    release_reset();
    step(); chk("R2", "fetch step1 mar", 32'(dbg_mar), 32'h000);
    step(); chk("R11", "fetch step2 mbr preloaded", 32'(dbg_mbr), 32'h1450);
    step(); chk("R2", "fetch step3 ir", 32'(dbg_ir), 32'h1450);
    chk("R2", "pc before step4", 32'(dbg_pc), 32'h000);
    step(); chk("R2", "fetch step4 pc", 32'(dbg_pc), 32'h001);
    step(); chk("R3", "load mar", 32'(dbg_mar), 32'h450);
    chk("R3", "ac before final", 32'(dbg_ac), 32'h0000);
    step(); chk("R3", "load mbr", 32'(dbg_mbr), 32'h0733);
    step(); chk("R3", "load ac", 32'(dbg_ac), 32'h0733);
    run_to_halt(s);
  endtask

  task automatic t_basic();
    int s;
    logic [11:0] pc_h;
    logic [15:0] ac_h;
    logic [15:0] ir_h;
    hold_reset();
    preload(12'h000, 16'h1100);
    preload(12'h001, 16'h3101);
    preload(12'h002, 16'h2102);
    preload(12'h003, 16'h1103);
    preload(12'h004, 16'h1102);
    preload(12'h005, 16'h0000);
    preload(12'h100, 16'h0001);
    preload(12'h101, 16'h0009);
    preload(12'h102, 16'h0000);
    preload(12'h103, 16'h4444);
    release_reset();
    run_to_halt(s);
    chk("R4", "stored sum read back", 32'(dbg_ac), 32'h0010);
    chk("R6", "pc after halt", 32'(dbg_pc), 32'h006);
    pc_h = dbg_pc; ac_h = dbg_ac; ir_h = dbg_ir;
    for (int i = 0; i < 20; i++) step();
    chk("R6", "halted holds", {31'd0, halted}, 32'd1);
    chk("R6", "pc frozen", 32'(dbg_pc), 32'(pc_h));
    chk("R6", "ac frozen", 32'(dbg_ac), 32'(ac_h));
    chk("R6", "ir frozen", 32'(dbg_ir), 32'(ir_h));
  endtask

  task automatic t_add(input logic [15:0] a, input logic [15:0] b, input logic [15:0] e);
    int s;
    hold_reset();
    preload(12'h000, 16'h1100);
    preload(12'h001, 16'h3101);
    preload(12'h002, 16'h0000);
    preload(12'h100, a);
    preload(12'h101, b);
    release_reset();
    run_to_halt(s);
    chk("R5", $sformatf("bcd add %h+%h", a, b), 32'(dbg_ac), 32'(e));
  endtask

  task automatic t_timing();
    int s;
    hold_reset();
    preload(12'h000, 16'h1100);
    preload(12'h001, 16'h3101);
    preload(12'h002, 16'h2102);
    preload(12'h003, 16'h0000);
    preload(12'h100, 16'h0004);
    preload(12'h101, 16'h0005);
    release_reset();
    run_to_halt(s);
    chk("R6", "micro-steps to halt", 32'(s), 32'd29);
  endtask

  task automatic t_unknown();
    int s;
    hold_reset();
    preload(12'h000, 16'h1100);
    preload(12'h001, 16'h5101);
    preload(12'h002, 16'h8101);
    preload(12'h003, 16'h2102);
    preload(12'h004, 16'h1101);
    preload(12'h005, 16'h3102);
    preload(12'h006, 16'h0000);
    preload(12'h100, 16'h0042);
    preload(12'h101, 16'h0777);
    preload(12'h102, 16'h0000);
    release_reset();
    for (int i = 0; i < 20; i++) step();
    chk("R10", "ac after ops 5 and 8", 32'(dbg_ac), 32'h0042);
    run_to_halt(s);
    chk("R10", "memory untouched, ac", 32'(dbg_ac), 32'h0819);
    chk("R10", "pc after halt", 32'(dbg_pc), 32'h007);
  endtask

  task automatic t_irq();
    int  s;
    bit  seen_isr;
    bit  ret_seen;
    hold_reset();
    preload(12'h000, 16'h1100);
    preload(12'h001, 16'h3101);
    preload(12'h002, 16'h0000);
    preload(12'h100, 16'h0005);
    preload(12'h101, 16'h0020);
    preload(12'h102, 16'h0300);
    preload(12'h998, 16'h3102);
    preload(12'h999, 16'h9000);
    irq = 1'b1;
    release_reset();
    seen_isr = 1'b0;
    ret_seen = 1'b0;
    s = 0;
    while (!halted && s < 1000) begin
      step();
      s++;
      if (dbg_pc == 12'h998) seen_isr = 1'b1;
      if (!ret_seen && dbg_ir == 16'h9000) begin
        ret_seen = 1'b1;
        irq = 1'b0;
        step();
        s++;
        chk("R7", "pc wraps 999 to 000", 32'(dbg_pc), 32'h000);
      end
    end
    chk("R8", "handler entered", {31'd0, seen_isr}, 32'd1);
    chk("R9", "single handler pass, ac", 32'(dbg_ac), 32'h0325);
    chk("R9", "resumed and halted, pc", 32'(dbg_pc), 32'h003);
  endtask

  initial begin
    n_run  = 0;
    n_fail = 0;
    cyc    = 0;
    rst_n  = 1'b0;
    irq    = 1'b0;
    pl_we  = 1'b0;
    pl_addr = '0;
    pl_data = '0;
    @(negedge clk);
    t_reset();
    t_micro();
    t_basic();
    t_add(16'h0001, 16'h0009, 16'h0010);
    t_add(16'h0999, 16'h0001, 16'h1000);
    t_add(16'h9999, 16'h0002, 16'h0001);
    t_add(16'h0358, 16'h0647, 16'h1005);
    t_timing();
    t_unknown();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule